// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Front End

This block is a clocked model of the control front end that sits behind the pins of a byte-wide NAND flash device. All pin inputs are sampled on the system clock. The block detects the rising edge of the write strobe and the falling edge of the read strobe. From those edges it latches command bytes and assembles a multi-byte address. It keeps a column pointer into a small page buffer and decides, cycle by cycle, whether the data bus is driven.

It raises one-cycle start pulses for program and erase toward an array that is not part of this block. It also follows the array's busy level. It produces a ready indication that is always driven and never floats. A reset command starts a fixed busy window whose length is set by a parameter. Deselecting the chip drops a read back to standby, but a program or erase still in flight is not disturbed by deselect. A spare-exclusion input limits the column range to the main part of the page. A write-protect input blocks, or aborts, program and erase work.

Top module: `nand_bus_front`

## Requirements
- R1: With chip enable (active-low) asserted, a rising write strobe while command-latch is high and address-latch is low stores the bus byte on `cmd_o`; strobes while chip enable is high change nothing.
- R2: Address-latch strobes fill the column first, then row bytes with the first row byte in `row_addr_o[7:0]`; bytes beyond the last row byte are dropped, and every latched command restarts the sequence at the column.
- R3: In read mode (entered by command 00h), each falling read strobe loads the buffer byte at the column onto `io_o` and advances the column by one; past the last byte it wraps to 0.
- R4: With `se_i` high the column wraps from MAIN_BYTES-1 to 0, and a data-input strobe at a column at or above MAIN_BYTES leaves the buffer unchanged.
- R5: `io_oe_o` is high only while chip enable is low, the read strobe is low, the write strobe is high and the mode is read or status; at reset it is low, `rdy_o` is high and `cmd_o` is 00h.
- R6: Chip enable going high in read or status mode with no program or erase pending returns to standby, after which a read strobe leaves the bus undriven.
- R7: While a program or erase is pending, chip enable high is ignored and the status byte stays readable.
- R8: Command FFh drives `rdy_o` low for exactly RST_CYC clock cycles after the latching edge and returns the mode to standby.
- R9: `rdy_o` is low while `array_busy_i` is high; the status byte (command 70h, and automatically after a program or erase start) has bit 7 equal to `wp_n_i`, bit 6 equal to ready and bits 5..0 zero.
- R10: Command 10h after 80h pulses `prog_go_o` for one cycle, and D0h after 60h pulses `erase_go_o` for one cycle, only when `wp_n_i` is high.
- R11: `wp_n_i` going low while a program or erase is pending gives a one-cycle `abort_o` pulse and ends the pending operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command-latch qualifier |
| ale_i | input | 1 | Address-latch qualifier |
| we_n_i | input | 1 | Write strobe, latches on rising edge |
| re_n_i | input | 1 | Read strobe, advances on falling edge |
| wp_n_i | input | 1 | Write protect, active low |
| se_i | input | 1 | Spare-area exclusion |
| io_i | input | 8 | Bus byte in |
| array_busy_i | input | 1 | Array operation in progress |
| io_o | output | 8 | Bus byte out |
| io_oe_o | output | 1 | Bus drive enable (low = high impedance) |
| rdy_o | output | 1 | Ready (low = busy), always driven |
| cmd_o | output | 8 | Last latched command |
| col_o | output | $clog2(MAIN_BYTES+SPARE_BYTES) | Column pointer |
| row_addr_o | output | 8*ROW_BYTES | Assembled row address |
| prog_go_o | output | 1 | Program start pulse |
| erase_go_o | output | 1 | Erase start pulse |
| abort_o | output | 1 | Write-protect abort pulse |

## Verification
The bench builds the block with an 8-byte main area, 2 spare bytes, 2 row bytes and a 5-cycle reset window. These small values let a few strobes reach both column wrap points, so every byte of the buffer can be written and read back. The reset window is short enough to count cycle by cycle. The extra address byte that follows the second row byte also shows that overflow address bytes are dropped.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  typedef enum logic [2:0] {M_IDLE, M_READ, M_DATAIN, M_ERASE, M_STATUS} nbf_mode_e;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_DIN    = 8'h80;
  localparam logic [7:0] OP_PROG   = 8'h10;
  localparam logic [7:0] OP_ERASE  = 8'h60;
  localparam logic [7:0] OP_ERGO   = 8'hD0;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  // next column with wrap at the active limit
  function automatic int unsigned col_step(int unsigned col, int unsigned lim);
    return (col + 1 >= lim) ? 0 : col + 1;
  endfunction

  function automatic logic [7:0] status_byte(logic wp_n, logic rdy);
    return {wp_n, rdy, 6'b0};
  endfunction
endpackage

// File: rtl/nbf_edge.sv
module nbf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic re_n,
  output logic we_rise,
  output logic re_fall
);
  logic we_q, re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_rise = !ce_n && !we_q && we_n;
  assign re_fall = !ce_n && re_q && !re_n;

  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise |=> !we_rise);
endmodule

// File: rtl/nbf_ctrl.sv
module nbf_ctrl import nbf_pkg::*; #(
  parameter int ROW_BYTES = 3,
  parameter int RST_CYC   = 250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   cle,
  input  logic                   ale,
  input  logic                   wp_n,
  input  logic [7:0]             io_i,
  input  logic                   we_rise,
  input  logic                   re_fall,
  input  logic                   array_busy,
  output logic [7:0]             cmd_o,
  output logic [ROW_BYTES*8-1:0] row_addr_o,
  output logic                   col_load,
  output logic                   col_clr,
  output logic                   din_stb,
  output logic                   rd_stb,
  output logic                   rd_status,
  output logic                   mode_rd,
  output logic                   rdy_o,
  output logic                   prog_go_o,
  output logic                   erase_go_o,
  output logic                   abort_o
);
  localparam int AIW = $clog2(ROW_BYTES + 2);
  localparam int RCW = $clog2(RST_CYC + 1);

  nbf_mode_e      mode_q;
  logic [AIW-1:0] aidx_q;
  logic [RCW-1:0] rcnt_q;
  logic           op_active, busy_q;
  logic           cmd_stb, addr_stb, rst_start, prog_ok, erase_ok, busy_fall;

  // named events
  assign cmd_stb   = we_rise && cle && !ale;
  assign addr_stb  = we_rise && ale && !cle;
  assign din_stb   = we_rise && !cle && !ale && (mode_q == M_DATAIN);
  assign rst_start = cmd_stb && (io_i == OP_RESET);
  assign prog_ok   = cmd_stb && (io_i == OP_PROG) && (mode_q == M_DATAIN) && wp_n;
  assign erase_ok  = cmd_stb && (io_i == OP_ERGO) && (mode_q == M_ERASE) && wp_n;
  assign busy_fall = busy_q && !array_busy;
  assign col_load  = addr_stb && (aidx_q == '0);
  assign col_clr   = cmd_stb;
  assign mode_rd   = (mode_q == M_READ) || (mode_q == M_STATUS);
  assign rd_stb    = re_fall && mode_rd;
  assign rd_status = (mode_q == M_STATUS);
  assign rdy_o     = (rcnt_q == '0) && !array_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o  <= OP_READ;
      mode_q <= M_IDLE;
      aidx_q <= '0;
    end else if (cmd_stb) begin
      cmd_o  <= io_i;
      aidx_q <= '0;
      case (io_i)
        OP_READ:   mode_q <= M_READ;
        OP_DIN:    mode_q <= M_DATAIN;
        OP_ERASE:  mode_q <= M_ERASE;
        OP_STATUS: mode_q <= M_STATUS;
        OP_PROG:   mode_q <= (mode_q == M_DATAIN) ? M_STATUS : M_IDLE;
        OP_ERGO:   mode_q <= (mode_q == M_ERASE) ? M_STATUS : M_IDLE;
        default:   mode_q <= M_IDLE;
      endcase
    end else begin
      if (addr_stb && (int'(aidx_q) <= ROW_BYTES)) aidx_q <= aidx_q + 1'b1;
      if (ce_n && !op_active && mode_rd) mode_q <= M_IDLE;
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_addr_o[g*8 +: 8] <= '0;
      else if (addr_stb && (int'(aidx_q) == g + 1)) row_addr_o[g*8 +: 8] <= io_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q     <= '0;
      op_active  <= 1'b0;
      busy_q     <= 1'b0;
      prog_go_o  <= 1'b0;
      erase_go_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      busy_q     <= array_busy;
      prog_go_o  <= prog_ok;
      erase_go_o <= erase_ok;
      abort_o    <= op_active && !wp_n;
      if (rst_start)           rcnt_q <= RCW'(RST_CYC);
      else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
      if (prog_ok || erase_ok) op_active <= 1'b1;
      else if (rst_start || busy_fall || !wp_n) op_active <= 1'b0;
    end
  end

  a_r8_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> !rdy_o);
  a_r7_ce_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && ce_n) |=> (mode_q == $past(mode_q)));
  a_r10_go_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go_o, erase_go_o}));
  a_r10_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go_o |=> !prog_go_o);
  a_r11_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !op_active);
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(aidx_q) <= ROW_BYTES + 1);
endmodule

// File: rtl/nbf_pgbuf.sv
module nbf_pgbuf import nbf_pkg::*; #(
  parameter int MAIN_BYTES  = 32,
  parameter int SPARE_BYTES = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        se,
  input  logic                                        col_clr,
  input  logic                                        col_load,
  input  logic [7:0]                                  io_i,
  input  logic                                        din_stb,
  input  logic                                        rd_stb,
  input  logic                                        rd_status,
  input  logic                                        wp_n,
  input  logic                                        rdy,
  output logic [7:0]                                  dout,
  output logic [$clog2(MAIN_BYTES+SPARE_BYTES)-1:0]   col_o
);
  localparam int TOTAL = MAIN_BYTES + SPARE_BYTES;
  localparam int CW    = $clog2(TOTAL);

  logic [7:0]  mem [TOTAL];
  int unsigned lim;
  logic [CW-1:0] col_nx;
  logic        wr_ok;

  assign lim    = se ? MAIN_BYTES : TOTAL;
  assign col_nx = CW'(col_step(int'(col_o), lim));
  assign wr_ok  = din_stb && !(se && (int'(col_o) >= MAIN_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o <= '0;
      dout  <= '0;
    end else begin
      if (col_clr) col_o <= '0;
      // out-of-range column bytes load column 0
      else if (col_load) col_o <= (int'(io_i) < TOTAL) ? CW'(io_i) : '0;
      else if (din_stb || (rd_stb && !rd_status)) col_o <= col_nx;
      if (rd_stb) dout <= rd_status ? status_byte(wp_n, rdy) : mem[col_o];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[col_o] <= io_i;
  end

  a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_o) < TOTAL);
  a_r4_se_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_status && se && !col_clr && !col_load && (int'(col_o) == MAIN_BYTES - 1))
      |=> (col_o == '0));
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front #(
  parameter int MAIN_BYTES  = 32,
  parameter int SPARE_BYTES = 8,
  parameter int ROW_BYTES   = 3,
  parameter int RST_CYC     = 250
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      ce_n_i,
  input  logic                                      cle_i,
  input  logic                                      ale_i,
  input  logic                                      we_n_i,
  input  logic                                      re_n_i,
  input  logic                                      wp_n_i,
  input  logic                                      se_i,
  input  logic [7:0]                                io_i,
  input  logic                                      array_busy_i,
  output logic [7:0]                                io_o,
  output logic                                      io_oe_o,
  output logic                                      rdy_o,
  output logic [7:0]                                cmd_o,
  output logic [$clog2(MAIN_BYTES+SPARE_BYTES)-1:0] col_o,
  output logic [ROW_BYTES*8-1:0]                    row_addr_o,
  output logic                                      prog_go_o,
  output logic                                      erase_go_o,
  output logic                                      abort_o
);
  logic we_rise, re_fall;
  logic col_load, col_clr, din_stb, rd_stb, rd_status, mode_rd;

  nbf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_i), .we_n(we_n_i), .re_n(re_n_i),
    .we_rise(we_rise), .re_fall(re_fall)
  );

  nbf_ctrl #(.ROW_BYTES(ROW_BYTES), .RST_CYC(RST_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_i), .cle(cle_i), .ale(ale_i),
    .wp_n(wp_n_i), .io_i(io_i), .we_rise(we_rise), .re_fall(re_fall),
    .array_busy(array_busy_i), .cmd_o(cmd_o), .row_addr_o(row_addr_o),
    .col_load(col_load), .col_clr(col_clr), .din_stb(din_stb),
    .rd_stb(rd_stb), .rd_status(rd_status), .mode_rd(mode_rd),
    .rdy_o(rdy_o), .prog_go_o(prog_go_o), .erase_go_o(erase_go_o),
    .abort_o(abort_o)
  );

  nbf_pgbuf #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .se(se_i), .col_clr(col_clr),
    .col_load(col_load), .io_i(io_i), .din_stb(din_stb), .rd_stb(rd_stb),
    .rd_status(rd_status), .wp_n(wp_n_i), .rdy(rdy_o), .dout(io_o),
    .col_o(col_o)
  );

  assign io_oe_o = !ce_n_i && !re_n_i && we_n_i && mode_rd;

  a_r5_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe_o |-> (!ce_n_i && we_n_i));
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy_i |-> !rdy_o);
endmodule

// File: tb/nand_bus_front_bench.sv
module nand_bus_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAINB = 8;
  localparam int SPAREB = 2;
  localparam int ROWB = 2;
  localparam int RSTC = 5;
  localparam int CW = $clog2(MAINB + SPAREB);

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1, se = 0, busy = 0;
  logic [7:0] io = 0;
  logic [7:0] io_o, cmd_o;
  logic io_oe, rdy, prog_go, erase_go, abort_p;
  logic [CW-1:0] col;
  logic [ROWB*8-1:0] row;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_front #(.MAIN_BYTES(MAINB), .SPARE_BYTES(SPAREB), .ROW_BYTES(ROWB),
                   .RST_CYC(RSTC)) u_nand_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale),
    .we_n_i(we_n), .re_n_i(re_n), .wp_n_i(wp_n), .se_i(se), .io_i(io),
    .array_busy_i(busy), .io_o(io_o), .io_oe_o(io_oe), .rdy_o(rdy),
    .cmd_o(cmd_o), .col_o(col), .row_addr_o(row), .prog_go_o(prog_go),
    .erase_go_o(erase_go), .abort_o(abort_p)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of the column step
  function automatic int nxt(int c, bit s);
    int lim = s ? MAINB : MAINB + SPAREB;
    return (c + 1 == lim || c + 1 > lim) ? 0 : c + 1;
  endfunction

  task automatic wr(bit c, bit a, logic [7:0] b);
    @(negedge clk); ce_n = 0; cle = c; ale = a; io = b; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic rd(output logic [7:0] b, output logic oe);
    @(negedge clk); re_n = 0;
    @(negedge clk); b = io_o; oe = io_oe; re_n = 1;
  endtask

  task automatic t_reset;
    check("R5 reset oe", io_oe, 0);
    check("R5 reset rdy", rdy, 1);
    check("R5 reset cmd", cmd_o, 8'h00);
    check("R10 reset go", prog_go, 0);
  endtask

  task automatic t_cmd_addr;
    wr(1, 0, 8'h80);
    check("R1 cmd latch", cmd_o, 8'h80);
    wr(0, 1, 8'h03); wr(0, 1, 8'h12); wr(0, 1, 8'h34); wr(0, 1, 8'h56);
    check("R2 column", col, 3);
    check("R2 row low first, extra dropped", row, 16'h3412);
    @(negedge clk); ce_n = 1; cle = 1; io = 8'h70; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0;
    check("R1 ignored when deselected", cmd_o, 8'h80);
    wr(1, 0, 8'h00); wr(0, 1, 8'h07);
    check("R2 restart at column", col, 7);
    check("R2 rows kept", row, 16'h3412);
  endtask

  task automatic t_program;
    se = 0;
    wr(1, 0, 8'h80); wr(0, 1, 0); wr(0, 1, 0); wr(0, 1, 0);
    for (int i = 0; i < MAINB + SPAREB; i++) wr(0, 0, 8'hA0 + 8'(i));
    check("R3 column wrapped after full page", col, 0);
    wr(1, 0, 8'h10);
    check("R10 prog pulse", prog_go, 1);
    @(negedge clk);
    check("R10 prog one cycle", prog_go, 0);
    busy = 1; @(negedge clk);
    check("R9 busy not ready", rdy, 0);
    busy = 0; @(negedge clk);
    check("R9 ready after busy", rdy, 1);
  endtask

  task automatic t_read;
    logic [7:0] b; logic oe; int c = 0;
    wr(1, 0, 8'h00); wr(0, 1, 0); wr(0, 1, 0); wr(0, 1, 0);
    for (int i = 0; i < MAINB + SPAREB + 1; i++) begin
      rd(b, oe);
      check("R3 read data", b, 8'hA0 + c);
      check("R5 oe while reading", oe, 1);
      c = nxt(c, 0);
    end
    @(negedge clk);
    check("R5 float with read strobe high", io_oe, 0);
  endtask

  task automatic t_spare;
    logic [7:0] b; logic oe;
    se = 1;
    wr(1, 0, 8'h80); wr(0, 1, 8'h08); wr(0, 0, 8'h99);
    check("R4 column wraps at main", col, 0);
    se = 0;
    wr(1, 0, 8'h00); wr(0, 1, 8'h08);
    rd(b, oe);
    check("R4 spare write ignored", b, 8'hA8);
    se = 1;
    wr(1, 0, 8'h00); wr(0, 1, 8'h06);
    rd(b, oe); check("R4 read col6", b, 8'hA6);
    rd(b, oe); check("R4 read col7", b, 8'hA7);
    rd(b, oe); check("R4 wrap to col0", b, 8'hA0);
    se = 0;
  endtask

  task automatic t_standby;
    logic [7:0] b; logic oe;
    wr(1, 0, 8'h00); wr(0, 1, 0);
    rd(b, oe); check("R6 read before standby", oe, 1);
    @(negedge clk); ce_n = 1;
    @(negedge clk); @(negedge clk); ce_n = 0;
    rd(b, oe); check("R6 no drive after standby", oe, 0);
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    check("R5 float when deselected", io_oe, 0);
  endtask

  task automatic t_erase_busy;
    logic [7:0] b; logic oe;
    wr(1, 0, 8'h60); wr(0, 1, 0); wr(0, 1, 8'h05); wr(0, 1, 0);
    wr(1, 0, 8'hD0);
    check("R10 erase pulse", erase_go, 1);
    busy = 1;
    @(negedge clk); ce_n = 1;
    check("R10 erase one cycle", erase_go, 0);
    repeat (3) @(negedge clk);
    ce_n = 0;
    rd(b, oe);
    check("R7 status still driven", oe, 1);
    check("R9 status busy", b, 8'h80);
    busy = 0;
    repeat (2) @(negedge clk);
    rd(b, oe);
    check("R9 status ready", b, 8'hC0);
    @(negedge clk); ce_n = 1;
    @(negedge clk); ce_n = 0;
    rd(b, oe);
    check("R6 standby after op done", oe, 0);
  endtask

  task automatic t_protect;
    logic [7:0] b; logic oe; int seen = 0;
    wp_n = 0;
    wr(1, 0, 8'h80);
    wr(1, 0, 8'h10);
    seen = prog_go;
    @(negedge clk); seen += prog_go;
    check("R10 protected no pulse", seen, 0);
    wr(1, 0, 8'h70);
    rd(b, oe);
    check("R9 status protected", b, 8'h40);
    wp_n = 1;
    wr(1, 0, 8'h80); wr(1, 0, 8'h10);
    check("R10 pulse when unprotected", prog_go, 1);
    busy = 1;
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    check("R11 abort pulse", abort_p, 1);
    @(negedge clk);
    check("R11 abort one cycle", abort_p, 0);
    wp_n = 1; busy = 0;
    @(negedge clk);
  endtask

  task automatic t_reset_cmd;
    logic [7:0] b; logic oe; int lows = 0;
    wr(1, 0, 8'h00);
    wr(1, 0, 8'hFF);
    for (int k = 0; k < RSTC + 3; k++) begin
      if (!rdy) lows++;
      @(negedge clk);
    end
    check("R8 busy cycles", lows, RSTC);
    check("R8 ready again", rdy, 1);
    rd(b, oe);
    check("R8 standby after reset", oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cmd_addr;
    t_program;
    t_read;
    t_spare;
    t_standby;
    t_erase_busy;
    t_protect;
    t_reset_cmd;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule